// File: doc/BRIEF.md
# Synchronous Character Framing Receiver

This block sits behind a synchronous serial line whose bit clock is shared with the far end. A one-cycle bit enable marks each sampled data bit. At first the block hunts for character alignment. In pattern modes, every new bit is slid into a 16-bit window. The newest bits of that window are compared with the upper bits of a left-justified sync register, using 6, 8, 12 or 16 of them. In external mode, framing is instead started by a strobe that is high on the first data bit of the first character.

Once aligned, the block stops hunting. It packs each following group of eight bits into a byte, least significant bit first, and presents the byte with a one-cycle valid pulse. A restart command drops alignment and begins a fresh hunt. Clock recovery, error checking and any policy on discarding repeated sync characters are left to the surrounding logic.

Top module: `sync_hunt_rx`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `rx_byte` is 0, `byte_valid` is 0 and `sync_found` is 0.
- R2: Bits arrive least significant bit first: the first bit of a character lands in `rx_byte[0]` and the eighth lands in `rx_byte[7]`.
- R3: `mode` selects the sync length: 0 means 6 bits, 1 means 8, 2 means 12 and 3 means 16. The last N received bits are compared with `sync_pat[15:16-N]`, and the earliest received of those N bits pairs with `sync_pat[16-N]`.
- R4: When a bit completes a match while hunting, `sync_found` is high from the next cycle. The bit after that one is the first bit of the first character.
- R5: Once synced, every eighth received bit makes `byte_valid` high for exactly one cycle, in the cycle after that bit's enable. `rx_byte` carries the new byte from that cycle and holds it until the next byte.
- R6: Cycles with `bit_en` low, and no restart, change neither the alignment nor the outputs. `byte_valid` is low after such a cycle.
- R7: A pattern match counts only after at least N bits have been received since reset or since the last restart.
- R8: `mode` values 4 to 7 select external framing, and pattern matching is then off. A bit received with `ext_sync` high while hunting is bit 0 of the first character, and `sync_found` is high from the next cycle.
- R9: A cycle with `hunt_restart` high ends with `sync_found` low and `byte_valid` low. It also clears the bit position and the received-bit count, and that cycle's bit is not counted.
- R10: While synced, sync patterns in the data and `ext_sync` are ignored. Characters keep their alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe marking a valid `rx_bit` |
| rx_bit | input | 1 | Serial data bit |
| mode | input | 3 | 0/1/2/3 = 6/8/12/16-bit sync, 4..7 = external framing |
| sync_pat | input | 16 | Left-justified sync pattern |
| ext_sync | input | 1 | External framing strobe, sampled with `bit_en` |
| hunt_restart | input | 1 | Drop alignment and hunt again |
| rx_byte | output | 8 | Last assembled character |
| byte_valid | output | 1 | One-cycle pulse when `rx_byte` is new |
| sync_found | output | 1 | High once character alignment is established |

## Verification
The common monosync byte (hex 16) is placed after noise bits, so that the bench can confirm the exact bit where alignment is declared. A pattern that differs by one bit is fed next and must never align. The all-zero pattern is tried straight after reset and restart, which shows that the received-bit guard holds back a false match on the empty window. The 6-, 12- and 16-bit lengths are run with idle gaps between bits, which separates the length selection from the bit-enable gating. External mode is fed a stream containing the sync pattern, followed by the strobe. This shows that matching is off and that the strobed bit is bit 0. A restart in the middle of a character and a sync byte inside the data check that alignment is neither kept after a restart nor moved by the data.

// File: rtl/sync_hunt_pkg.sv
// Shared constants for the sync hunt receiver.
// Assumes the sync window is 16 bits and four pattern lengths are offered.
package sync_hunt_pkg;
    localparam int SYNC_W = 16;
    localparam int N_LEN  = 4;

    // Pattern length chosen by mode code 0..3.
    function automatic int sync_len(input int code);
        case (code)
            0:       return 6;
            1:       return 8;
            2:       return 12;
            default: return 16;
        endcase
    endfunction
endpackage

// File: rtl/sync_window.sv
// Sliding window of received bits plus a saturating count of bits since the
// last reset or restart. Newest bit enters at the MSB.
// Assumes bit_en is a single-cycle strobe per data bit.
module sync_window #(
    parameter int W     = 16,
    localparam int CW   = $clog2(W) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          rx_bit,
    input  logic          restart,
    output logic [W-1:0]  win_next,
    output logic [CW-1:0] fill_next
);
    logic [W-1:0]  win_q;
    logic [CW-1:0] fill_q;

    // Next window contents with the incoming bit shifted in at the top.
    always_comb win_next = bit_en ? {rx_bit, win_q[W-1:1]} : win_q;

    // Next received-bit count, saturating at the window width.
    always_comb begin
        if (restart)
            fill_next = '0;
        else if (bit_en && (fill_q < CW'(W)))
            fill_next = fill_q + 1'b1;
        else
            fill_next = fill_q;
    end

    // Register the window and the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q  <= '0;
            fill_q <= '0;
        end else begin
            win_q  <= win_next;
            fill_q <= fill_next;
        end
    end
endmodule

// File: rtl/pattern_matcher.sv
// Compares the top N bits of the window with the top N bits of the
// left-justified sync pattern, for each supported N, then picks one by mode.
// Assumes the window and the count given are the values after this bit.
module pattern_matcher
    import sync_hunt_pkg::*;
#(
    parameter int W   = SYNC_W,
    localparam int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  win_next,
    input  logic [CW-1:0] fill_next,
    input  logic [W-1:0]  sync_pat,
    input  logic [1:0]    len_sel,
    output logic          hit
);
    logic [N_LEN-1:0] hit_v;

    // One masked comparator per pattern length.
    for (genvar k = 0; k < N_LEN; k++) begin : g_len
        localparam int            L    = sync_len(k);
        localparam logic [W-1:0]  MASK = ~({W{1'b1}} >> L);
        assign hit_v[k] = (((win_next ^ sync_pat) & MASK) == '0)
                          && (fill_next >= CW'(L));
    end

    // Select the comparator for the configured length.
    always_comb hit = hit_v[len_sel];
endmodule

// File: rtl/frame_ctrl.sv
// Hunt/synced state, bit position within a character and byte output.
// Assumes hit and win_next describe the window including the current bit.
module frame_ctrl #(
    parameter int CHAR_W = 8,
    parameter int W      = 16,
    localparam int PW    = $clog2(CHAR_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              restart,
    input  logic              ext_mode,
    input  logic              ext_sync,
    input  logic              hit,
    input  logic [W-1:0]      win_next,
    output logic [CHAR_W-1:0] rx_byte,
    output logic              byte_valid,
    output logic              sync_found
);
    logic [PW-1:0] pos_q;

    // Framing state machine: hunt, align, then count bits per character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q      <= '0;
            rx_byte    <= '0;
            byte_valid <= 1'b0;
            sync_found <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (restart) begin
                sync_found <= 1'b0;
                pos_q      <= '0;
            end else if (bit_en) begin
                if (!sync_found) begin
                    if (ext_mode ? ext_sync : hit) begin
                        sync_found <= 1'b1;
                        pos_q      <= ext_mode ? PW'(1) : '0;
                    end
                end else if (pos_q == PW'(CHAR_W - 1)) begin
                    byte_valid <= 1'b1;
                    rx_byte    <= win_next[W-1 -: CHAR_W];
                    pos_q      <= '0;
                end else begin
                    pos_q <= pos_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sync_hunt_rx.sv
// Top of the sync hunt receiver: window, pattern comparators and framing.
// Assumes a shared bit clock marked by bit_en and LSB-first characters.
module sync_hunt_rx
    import sync_hunt_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic [2:0]        mode,
    input  logic [SYNC_W-1:0] sync_pat,
    input  logic              ext_sync,
    input  logic              hunt_restart,
    output logic [CHAR_W-1:0] rx_byte,
    output logic              byte_valid,
    output logic              sync_found
);
    localparam int CW = $clog2(SYNC_W) + 1;

    logic [SYNC_W-1:0] win_next;
    logic [CW-1:0]     fill_next;
    logic              hit;

    sync_window #(.W(SYNC_W)) u_win (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .restart(hunt_restart), .win_next(win_next), .fill_next(fill_next)
    );

    pattern_matcher #(.W(SYNC_W)) u_match (
        .win_next(win_next), .fill_next(fill_next), .sync_pat(sync_pat),
        .len_sel(mode[1:0]), .hit(hit)
    );

    frame_ctrl #(.CHAR_W(CHAR_W), .W(SYNC_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .restart(hunt_restart),
        .ext_mode(mode[2]), .ext_sync(ext_sync), .hit(hit),
        .win_next(win_next), .rx_byte(rx_byte), .byte_valid(byte_valid),
        .sync_found(sync_found)
    );
endmodule

// File: rtl/sync_hunt_rx_chk.sv
// Protocol checker for sync_hunt_rx, attached by bind.
// Assumes reset is held for at least one clock at start.
module sync_hunt_rx_chk #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic              rx_bit,
    input logic [2:0]        mode,
    input logic [15:0]       sync_pat,
    input logic              ext_sync,
    input logic              hunt_restart,
    input logic [CHAR_W-1:0] rx_byte,
    input logic              byte_valid,
    input logic              sync_found
);
    AST_VALID_WHEN_SYNCED: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> sync_found); // R5
    AST_VALID_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> $past(bit_en)); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !hunt_restart) |=> ($stable(rx_byte) && !byte_valid && $stable(sync_found))); // R6
    AST_RESTART_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_restart |=> (!sync_found && !byte_valid)); // R9
    AST_ALIGN_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_found) |-> ($past(bit_en) && !$past(hunt_restart))); // R4
    AST_EXT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sync_found) && $past(mode[2])) |-> $past(ext_sync)); // R8
endmodule

bind sync_hunt_rx sync_hunt_rx_chk #(.CHAR_W(CHAR_W)) u_chk (.*);

// File: tb/sync_hunt_rx_tb.sv
// Bench for sync_hunt_rx: behavioural reference model compared every clock.
module sync_hunt_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0, rx_bit = 1'b0, ext_sync = 1'b0, hunt_restart = 1'b0;
    logic [2:0]  mode = 3'd1;
    logic [15:0] sync_pat = 16'h1600;
    logic [7:0]  rx_byte;
    logic        byte_valid, sync_found;

    int    checks = 0, errors = 0;
    string cur_req = "R1";
    bit    gap_on = 0;

    // reference model state
    bit    m_hist[$];
    int    m_fill = 0, m_cnt = 0;
    bit    m_sync = 0, exp_valid = 0;
    logic [7:0] exp_byte = 8'h00;

    always #2.5 clk = ~clk;

    sync_hunt_rx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .mode(mode),
        .sync_pat(sync_pat), .ext_sync(ext_sync), .hunt_restart(hunt_restart),
        .rx_byte(rx_byte), .byte_valid(byte_valid), .sync_found(sync_found)
    );

    initial begin
        #(5 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic int len_of(input logic [2:0] m);
        case (m[1:0]) 2'd0: return 6; 2'd1: return 8; 2'd2: return 12; default: return 16; endcase
    endfunction

    // Advance the model by one clock using the current inputs.
    task automatic model_step();
        exp_valid = 0;
        if (bit_en) begin
            m_hist.push_back(rx_bit);
            if (m_hist.size() > 16) void'(m_hist.pop_front());
        end
        if (hunt_restart) begin
            m_sync = 0; m_cnt = 0; m_fill = 0;
        end else if (bit_en) begin
            if (m_fill < 16) m_fill++;
            if (!m_sync) begin
                if (mode[2]) begin
                    if (ext_sync) begin m_sync = 1; m_cnt = 1; end
                end else begin
                    int n = len_of(mode);
                    bit ok = (m_fill >= n);
                    for (int i = 0; i < n && ok; i++)
                        if (m_hist[m_hist.size() - n + i] != sync_pat[16 - n + i]) ok = 0;
                    if (ok) begin m_sync = 1; m_cnt = 0; end
                end
            end else begin
                m_cnt++;
                if (m_cnt == 8) begin
                    exp_valid = 1;
                    for (int i = 0; i < 8; i++) exp_byte[i] = m_hist[m_hist.size() - 8 + i];
                    m_cnt = 0;
                end
            end
        end
    endtask

    task automatic compare();
        checks++;
        if (rx_byte !== exp_byte || byte_valid !== exp_valid || sync_found !== m_sync) begin
            errors++;
            $display("FAIL %s t=%0t byte=%h valid=%b sync=%b expected byte=%h valid=%b sync=%b",
                     cur_req, $time, rx_byte, byte_valid, sync_found, exp_byte, exp_valid, m_sync);
        end
    endtask

    // One clock with given inputs; compare shortly after the edge.
    task automatic drive(input bit en, input bit d, input bit ext, input bit rs);
        @(negedge clk);
        bit_en = en; rx_bit = d; ext_sync = ext; hunt_restart = rs;
        model_step();
        @(posedge clk);
        #1;
        compare();
    endtask

    task automatic send_bit(input bit d);
        if (gap_on) drive(0, 0, 0, 0);
        drive(1, d, 0, 0);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
    endtask

    task automatic send_sync();
        int n = len_of(mode);
        for (int i = 16 - n; i < 16; i++) send_bit(sync_pat[i]);
    endtask

    task automatic expect_sync(input bit v, input string tag);
        checks++;
        if (sync_found !== v) begin
            errors++;
            $display("FAIL %s sync_found=%b expected %b", tag, sync_found, v);
        end
    endtask

    task automatic restart();
        drive(0, 0, 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (rx_byte !== 8'h00 || byte_valid !== 1'b0 || sync_found !== 1'b0) begin
            errors++;
            $display("FAIL R1 byte=%h valid=%b sync=%b expected 00 0 0", rx_byte, byte_valid, sync_found);
        end
        rst_n = 1'b1;
        drive(0, 0, 0, 0);

        // R7: all-zero 8-bit pattern needs 8 bits first
        cur_req = "R7"; mode = 3'd1; sync_pat = 16'h0000;
        for (int i = 0; i < 7; i++) send_bit(0);
        expect_sync(0, "R7 before 8 bits");
        send_bit(0);
        expect_sync(1, "R7 after 8 bits");
        restart();
        expect_sync(0, "R9 after restart");
        for (int i = 0; i < 5; i++) send_bit(0);
        expect_sync(0, "R7 count cleared by restart");
        restart();

        // R3/R4/R2/R5: monosync hex 16 after noise
        cur_req = "R4"; sync_pat = 16'h1600;
        send_byte(8'hA5); send_bit(1); send_bit(1);
        send_sync();
        expect_sync(1, "R4 aligned");
        cur_req = "R2"; send_byte(8'h3C);
        cur_req = "R5"; send_byte(8'hC3); send_byte(8'h5A);
        cur_req = "R10"; send_byte(8'h16); send_bit(0); send_bit(1); send_byte(8'h16);
        send_bit(1); drive(1, 0, 1, 0); send_byte(8'hF0);
        restart();

        // R3: near miss never aligns
        cur_req = "R3";
        for (int k = 0; k < 3; k++) send_byte(8'h17);
        expect_sync(0, "R3 near miss");
        restart();

        // R3/R6: 6-, 12- and 16-bit lengths with gaps
        gap_on = 1;
        cur_req = "R3"; mode = 3'd0; sync_pat = 16'h5800;
        send_byte(8'hFF); send_sync(); expect_sync(1, "R3 6-bit");
        cur_req = "R6"; send_byte(8'h81); send_byte(8'h7E);
        restart();
        cur_req = "R3"; mode = 3'd2; sync_pat = 16'hB5C0;
        send_byte(8'h00); send_sync(); expect_sync(1, "R3 12-bit");
        send_byte(8'h69);
        restart();
        mode = 3'd3; sync_pat = 16'h7E81;
        send_byte(8'h24); send_sync(); expect_sync(1, "R3 16-bit");
        cur_req = "R6"; send_byte(8'hE7);
        gap_on = 0;
        restart();

        // R8: external framing ignores patterns
        cur_req = "R8"; mode = 3'd4; sync_pat = 16'h1600;
        send_byte(8'h16); send_byte(8'h16);
        expect_sync(0, "R8 pattern ignored");
        drive(1, 1, 1, 0);
        expect_sync(1, "R8 strobe aligns");
        send_bit(0); send_bit(1); send_bit(1); send_bit(0); send_bit(0); send_bit(1); send_bit(0);
        send_byte(8'hB2);
        restart();
        mode = 3'd7;
        send_byte(8'h55); drive(1, 0, 1, 0); send_byte(8'h9C);

        // R9: restart in the middle of a character
        cur_req = "R9"; restart(); mode = 3'd1;
        send_sync(); send_bit(1); send_bit(0); send_bit(1);
        restart();
        expect_sync(0, "R9 mid-char restart");
        send_bit(1); send_bit(0);
        send_sync(); send_byte(8'hD4);
        drive(1, 1, 0, 1);
        send_byte(8'h12);
        drive(0, 0, 0, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule